// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds the joint code/data translation entries of a processor memory unit and lets software manage them through four registers: two descriptor words, an index register and a command register. Descriptor word 0 carries the virtual page number, the address-space identifier, a global bit and a valid bit. Descriptor word 1 carries the physical frame and the permission bits. Software loads these words and an index, then writes a command code. The engine runs the command in two internal steps and drops `busy` when it is done.

There are six commands. Probe searches the set picked by descriptor word 0 and reports the matching location, a miss, or a duplicate match. Get-index picks a slot in that set: a free way if there is one, otherwise a victim chosen by a round-robin pointer kept per set. Read copies an entry back into the descriptor registers. There are two write commands, and they differ only in whether they pulse the invalidate line to the attached micro-TLBs. A last command pulses that line alone. Entries are stored with set-major linear indexing, so the index is set × ways + way.

Top module: `tlb_cmd_engine`

## Requirements
- R1: After reset, register addresses 0 (descriptor word 0), 1 (descriptor word 1), 2 (index) and 3 (status) read 0, `busy` is 0 and `utlb_inval` is 0, and every entry is empty.
- R2: While idle, a write to address 0 or 1 loads that descriptor word, and it reads back unchanged. A write to address 2 loads the index field (the low log2(entries) bits, 9 bits by default) and clears both flag bits. The index register reads as {bit31 lookup error, bit30 duplicate, zeros, index}.
- R3: Command code 1 (write) stores both descriptor words at the entry addressed by the index field. Command code 2 (read) loads both descriptor words from that entry.
- R4: Command code 4 (probe) matches descriptor word 0 against every way of set word0[19:13]. A way matches when its stored valid bit (word0 bit 9) is 1, its bits [31:13] are equal to the key, and either its global bit (bit 8) is 1 or its ASID bits [7:0] are equal to the key. On exactly one match, the index register becomes set×WAYS+way with both flags clear.
- R5: A probe with no matching way leaves the index register at 0x8000_0000.
- R6: A probe with two or more matching ways leaves the index register at 0xC000_0000. Write commands store entries without any duplicate check.
- R7: Command code 3 (get-index) places set×WAYS+way in the index register and clears both flags, where the set is word0[19:13] and the way is the lowest-numbered way whose valid bit is 0.
- R8: When every way of the set is valid, get-index returns the way held by that set's round-robin pointer. The pointer starts at 0, advances by one (wrapping) after each such pick, and is separate for each set.
- R9: `utlb_inval` is high for exactly one cycle: the cycle in which `busy` first reads low after a write (code 1) or an invalidate-only command (code 6). Code 5 (write without invalidate) stores the entry like code 1 but leaves `utlb_inval` low. Code 6 changes no entry.
- R10: After a command is accepted, `busy` is high for exactly two cycles. Every register write made while `busy` is high is ignored.
- R11: Command codes 0 and 7 are not accepted: `busy` stays low and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 word 0, 1 word 1, 2 index, 3 command/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register selected by reg_addr (status reads busy in bit 0) |
| busy | output | 1 | A command is executing |
| utlb_inval | output | 1 | One-cycle micro-TLB invalidate pulse |

## Verification
The hardest states to reach are a set in which two ways hold the same key and a set in which every way is valid. The engine never creates either state by itself, so get-index alone cannot reach them. The stimulus reaches both by writing chosen descriptors at chosen linear indices with the write-without-invalidate command. It then probes the duplicated key and calls get-index repeatedly on the full set. A second full set shows that the round-robin pointers are independent, and erasing one way then shows that a free way wins over the pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int WORD_W  = 32;
    localparam int VPN_LSB = 13;
    localparam int ASID_W  = 8;
    localparam int GLB_BIT = 8;
    localparam int VLD_BIT = 9;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_GETIDX = 3'd3,
        OP_PROBE  = 3'd4,
        OP_WRNI   = 3'd5,
        OP_INVU   = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOK   = 2'd1,
        ST_COMMIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] w0;
        logic [WORD_W-1:0] w1;
    } entry_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [$clog2(SETS*WAYS)-1:0]         wr_idx,
    input  entry_t                               wr_data,
    input  logic [$clog2(SETS*WAYS)-1:0]         rd_idx,
    output entry_t                               rd_data,
    input  logic [$clog2(SETS)-1:0]              set_sel,
    output entry_t [WAYS-1:0]                    set_ents
);
    localparam int N  = SETS * WAYS;
    localparam int WB = $clog2(WAYS);

    entry_t mem_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_ents[w] = mem_q[{set_sel, WB'(w)}];
    end

    // R3: a written entry holds the written words one cycle later
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int WAYS = 4
) (
    input  entry_t [WAYS-1:0]       ents,
    input  logic [WORD_W-1:0]       key,
    output logic [WAYS-1:0]         hit,
    output logic [WAYS-1:0]         vld,
    output logic                    hit_any,
    output logic                    hit_multi,
    output logic [$clog2(WAYS)-1:0] hit_way
);
    localparam int WB = $clog2(WAYS);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        logic page_eq, asid_eq;
        assign vld[w]   = ents[w].w0[VLD_BIT];
        assign page_eq  = ents[w].w0[WORD_W-1:VPN_LSB] == key[WORD_W-1:VPN_LSB];
        assign asid_eq  = ents[w].w0[ASID_W-1:0] == key[ASID_W-1:0];
        assign hit[w]   = vld[w] && page_eq && (ents[w].w0[GLB_BIT] || asid_eq);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit[w]) hit_way = WB'(w);
        end
        hit_any   = |hit;
        hit_multi = $countones(hit) > 1;
    end

    // R4: a reported way really matched
    always_comb begin
        if (hit_any) a_r4_way_hits: assert (hit[hit_way]);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(SETS)-1:0] set_sel,
    input  logic [WAYS-1:0]         vld,
    input  logic                    adv,
    output logic [$clog2(WAYS)-1:0] pick_way,
    output logic                    pick_victim
);
    localparam int WB = $clog2(WAYS);

    logic [WB-1:0] rr_q [SETS];
    logic [WB-1:0] rr_d [SETS];

    always_comb begin
        pick_way    = rr_q[set_sel];
        pick_victim = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) begin
                pick_way    = WB'(w);
                pick_victim = 1'b0;
            end
        end
        rr_d = rr_q;
        if (adv && pick_victim) rr_d[set_sel] = rr_q[set_sel] + WB'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

    // R7: a free way is never passed over
    always_comb begin
        if (rst_n && !(&vld)) a_r7_free_first: assert (!vld[pick_way]);
    end

    // R8: each victim pick moves the set pointer by one
    a_r8_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && pick_victim) |=> rr_q[$past(set_sel)] == $past(rr_q[set_sel]) + WB'(1));
endmodule

// File: rtl/tlb_cmd_engine.sv
module tlb_cmd_engine
    import tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        busy,
    output logic        utlb_inval
);
    localparam int N  = SETS * WAYS;
    localparam int IW = $clog2(N);
    localparam int SW = $clog2(SETS);
    localparam int WB = $clog2(WAYS);

    typedef struct packed {
        phase_e             st;
        op_e                op;
        logic [WORD_W-1:0]  d0;
        logic [WORD_W-1:0]  d1;
        logic [IW-1:0]      idx;
        logic               err;
        logic               dup;
        logic [SW-1:0]      set;
        logic [WAYS-1:0]    vld;
        logic               any;
        logic               multi;
        logic [WB-1:0]      hway;
        logic               inv;
    } eng_t;

    eng_t q, d;

    entry_t              rd_ent;
    entry_t [WAYS-1:0]   set_ents;
    logic [WAYS-1:0]     m_hit, m_vld;
    logic                m_any, m_multi;
    logic [WB-1:0]       m_way;
    logic [WB-1:0]       v_way;
    logic                v_victim;
    logic                st_we;
    logic                v_adv;

    assign st_we = (q.st == ST_COMMIT) && (q.op == OP_WRITE || q.op == OP_WRNI);
    assign v_adv = (q.st == ST_COMMIT) && (q.op == OP_GETIDX);

    tlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (st_we),
        .wr_idx   (q.idx),
        .wr_data  ({q.d0, q.d1}),
        .rd_idx   (q.idx),
        .rd_data  (rd_ent),
        .set_sel  (q.d0[VPN_LSB +: SW]),
        .set_ents (set_ents)
    );

    tlb_match #(.WAYS(WAYS)) u_match (
        .ents      (set_ents),
        .key       (q.d0),
        .hit       (m_hit),
        .vld       (m_vld),
        .hit_any   (m_any),
        .hit_multi (m_multi),
        .hit_way   (m_way)
    );

    tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_sel     (q.set),
        .vld         (q.vld),
        .adv         (v_adv),
        .pick_way    (v_way),
        .pick_victim (v_victim)
    );

    always_comb begin
        d     = q;
        d.inv = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (reg_we) begin
                    unique case (reg_addr)
                        2'd0: d.d0 = reg_wdata;
                        2'd1: d.d1 = reg_wdata;
                        2'd2: begin
                            d.idx = reg_wdata[IW-1:0];
                            d.err = 1'b0;
                            d.dup = 1'b0;
                        end
                        default: begin
                            if (reg_wdata[2:0] != 3'd0 && reg_wdata[2:0] != 3'd7) begin
                                d.op = op_e'(reg_wdata[2:0]);
                                d.st = ST_LOOK;
                            end
                        end
                    endcase
                end
            end
            ST_LOOK: begin
                d.set   = q.d0[VPN_LSB +: SW];
                d.vld   = m_vld;
                d.any   = m_any;
                d.multi = m_multi;
                d.hway  = m_way;
                d.st    = ST_COMMIT;
            end
            ST_COMMIT: begin
                unique case (q.op)
                    OP_WRITE: d.inv = 1'b1;
                    OP_INVU:  d.inv = 1'b1;
                    OP_READ: begin
                        d.d0 = rd_ent.w0;
                        d.d1 = rd_ent.w1;
                    end
                    OP_GETIDX: begin
                        d.idx = {q.set, v_way};
                        d.err = 1'b0;
                        d.dup = 1'b0;
                    end
                    OP_PROBE: begin
                        if (q.multi) begin
                            d.idx = '0;
                            d.err = 1'b1;
                            d.dup = 1'b1;
                        end else if (q.any) begin
                            d.idx = {q.set, q.hway};
                            d.err = 1'b0;
                            d.dup = 1'b0;
                        end else begin
                            d.idx = '0;
                            d.err = 1'b1;
                            d.dup = 1'b0;
                        end
                    end
                    default: ;
                endcase
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.op <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy       = q.st != ST_IDLE;
    assign utlb_inval = q.inv;

    always_comb begin
        unique case (reg_addr)
            2'd0:    reg_rdata = q.d0;
            2'd1:    reg_rdata = q.d1;
            2'd2:    reg_rdata = {q.err, q.dup, {(30 - IW){1'b0}}, q.idx};
            default: reg_rdata = {31'd0, busy};
        endcase
    end

    // R10: the two execution steps follow each other without stalls
    a_r10_look_to_commit: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_LOOK |=> q.st == ST_COMMIT);
    a_r10_commit_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_COMMIT |=> q.st == ST_IDLE);
    // R10: writes during the lookup step leave the descriptors alone
    a_r10_desc_held: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_LOOK |=> $stable(q.d0) && $stable(q.d1));
    // R9: the invalidate pulse is one cycle and follows a commit step
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        utlb_inval |=> !utlb_inval);
    a_r9_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(utlb_inval) |-> $past(q.st) == ST_COMMIT);
    // R6: the duplicate code always carries the lookup error flag
    a_r6_dup_has_err: assert property (@(posedge clk) disable iff (!rst_n)
        q.dup |-> q.err);
endmodule

// File: tb/tlb_cmd_engine_test.sv
module tlb_cmd_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy;
    logic        utlb_inval;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_cmd_engine #(.SETS(128), .WAYS(4)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .utlb_inval (utlb_inval)
    );

    function automatic logic [31:0] mk0(input logic [18:0] vpn, input logic v,
                                        input logic g, input logic [7:0] asid);
        return {vpn, 3'b000, v, g, asid};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_cmd(input logic [2:0] c, output int bcy, output logic iv);
        wr_reg(2'd3, {29'd0, c});
        bcy = 0;
        while (busy && bcy < 10) begin
            bcy++;
            @(negedge clk);
        end
        iv = utlb_inval;
    endtask

    task automatic put(input logic [8:0] idx, input logic [31:0] w0,
                       input logic [31:0] w1);
        int b; logic iv;
        wr_reg(2'd2, {23'd0, idx});
        wr_reg(2'd0, w0);
        wr_reg(2'd1, w1);
        do_cmd(3'd5, b, iv);
    endtask

    task automatic probe(input logic [31:0] w0, output logic [31:0] res);
        int b; logic iv;
        wr_reg(2'd0, w0);
        do_cmd(3'd4, b, iv);
        rd_reg(2'd2, res);
    endtask

    task automatic getidx(input logic [31:0] w0, output logic [31:0] res);
        int b; logic iv;
        wr_reg(2'd0, w0);
        do_cmd(3'd3, b, iv);
        rd_reg(2'd2, res);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 32'h0);
        end
        chk("R1", "busy after reset", {31'd0, busy}, 32'h0);
        chk("R1", "utlb_inval after reset", {31'd0, utlb_inval}, 32'h0);
        probe(mk0(19'd3, 1'b1, 1'b0, 8'h11), v);
        chk("R1", "probe empty table", v, 32'h8000_0000);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        wr_reg(2'd0, 32'h1234_5678); rd_reg(2'd0, v);
        chk("R2", "word0 readback", v, 32'h1234_5678);
        wr_reg(2'd1, 32'h9ABC_DEF0); rd_reg(2'd1, v);
        chk("R2", "word1 readback", v, 32'h9ABC_DEF0);
        wr_reg(2'd2, 32'hFFFF_FFFF); rd_reg(2'd2, v);
        chk("R2", "index masked, flags clear", v, 32'h0000_01FF);
    endtask

    task automatic t_write_read;
        logic [31:0] v; int b; logic iv;
        wr_reg(2'd2, 32'd13);
        wr_reg(2'd0, mk0(19'd3, 1'b1, 1'b0, 8'h11));
        wr_reg(2'd1, 32'hABCD_E03F);
        do_cmd(3'd1, b, iv);
        chk("R10", "busy cycles of write", 32'(b), 32'd2);
        chk("R9", "write pulses invalidate", {31'd0, iv}, 32'h1);
        @(negedge clk);
        chk("R9", "pulse lasts one cycle", {31'd0, utlb_inval}, 32'h0);
        wr_reg(2'd0, 32'h0); wr_reg(2'd1, 32'h0);
        do_cmd(3'd2, b, iv);
        chk("R9", "read gives no pulse", {31'd0, iv}, 32'h0);
        rd_reg(2'd0, v);
        chk("R3", "read back word0", v, mk0(19'd3, 1'b1, 1'b0, 8'h11));
        rd_reg(2'd1, v);
        chk("R3", "read back word1", v, 32'hABCD_E03F);
    endtask

    task automatic t_probe;
        logic [31:0] v; int b; logic iv;
        probe(mk0(19'd3, 1'b1, 1'b0, 8'h11), v);
        chk("R4", "single hit at set3 way1", v, 32'd13);
        probe(mk0(19'd3, 1'b1, 1'b0, 8'h12), v);
        chk("R5", "asid mismatch miss", v, 32'h8000_0000);
        wr_reg(2'd2, 32'd18);
        wr_reg(2'd0, mk0(19'd4, 1'b1, 1'b1, 8'h22));
        wr_reg(2'd1, 32'h0000_2007);
        do_cmd(3'd5, b, iv);
        chk("R9", "write-no-invalidate no pulse", {31'd0, iv}, 32'h0);
        probe(mk0(19'd4, 1'b1, 1'b0, 8'h55), v);
        chk("R4", "global ignores asid", v, 32'd18);
        put(9'd28, mk0(19'd7, 1'b0, 1'b0, 8'h01), 32'h1);
        probe(mk0(19'd7, 1'b1, 1'b0, 8'h01), v);
        chk("R4", "invalid entry not matched", v, 32'h8000_0000);
        probe(mk0(19'h00083, 1'b1, 1'b0, 8'h11), v);
        chk("R5", "same set other page misses", v, 32'h8000_0000);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        wr_reg(2'd0, mk0(19'd4, 1'b1, 1'b0, 8'h55));
        wr_reg(2'd3, 32'd4);
        wr_reg(2'd0, 32'hDEAD_0000);
        wr_reg(2'd3, 32'd1);
        chk("R10", "busy low after two cycles", {31'd0, busy}, 32'h0);
        chk("R10", "ignored write cmd no pulse", {31'd0, utlb_inval}, 32'h0);
        @(negedge clk);
        chk("R10", "ignored command not started", {31'd0, busy}, 32'h0);
        rd_reg(2'd0, v);
        chk("R10", "word0 write while busy ignored", v, mk0(19'd4, 1'b1, 1'b0, 8'h55));
        rd_reg(2'd2, v);
        chk("R10", "probe ran with held key", v, 32'd18);
    endtask

    task automatic t_dup;
        logic [31:0] v;
        put(9'd14, mk0(19'd3, 1'b1, 1'b0, 8'h11), 32'h5);
        probe(mk0(19'd3, 1'b1, 1'b0, 8'h11), v);
        chk("R6", "duplicate match code", v, 32'hC000_0000);
    endtask

    task automatic t_getidx;
        logic [31:0] v;
        getidx(mk0(19'd9, 1'b1, 1'b0, 8'h0), v);
        chk("R7", "empty set way0", v, 32'd36);
        put(9'd36, mk0(19'd9, 1'b1, 1'b0, 8'h0), 32'h0);
        getidx(mk0(19'd9, 1'b1, 1'b0, 8'h0), v);
        chk("R7", "next free way", v, 32'd37);
        for (int w = 0; w < 4; w++) begin
            put(9'(20 + w), mk0(19'd5, 1'b1, 1'b0, 8'(w)), 32'h0);
            put(9'(24 + w), mk0(19'd6, 1'b1, 1'b0, 8'(w)), 32'h0);
        end
        for (int k = 0; k < 3; k++) begin
            getidx(mk0(19'd5, 1'b1, 1'b0, 8'h0), v);
            chk("R8", $sformatf("round robin pick %0d set5", k), v, 32'(20 + k));
        end
        getidx(mk0(19'd6, 1'b1, 1'b0, 8'h0), v);
        chk("R8", "pointer independent per set", v, 32'd24);
        put(9'd21, 32'h0, 32'h0);
        getidx(mk0(19'd5, 1'b1, 1'b0, 8'h0), v);
        chk("R7", "erased way preferred", v, 32'd21);
        getidx(mk0(19'd5, 1'b1, 1'b0, 8'h0), v);
        chk("R7", "free way does not move pointer", v, 32'd21);
        put(9'd21, mk0(19'd5, 1'b1, 1'b0, 8'h9), 32'h0);
        getidx(mk0(19'd5, 1'b1, 1'b0, 8'h0), v);
        chk("R8", "pointer resumes at way3", v, 32'd23);
        getidx(mk0(19'd5, 1'b1, 1'b0, 8'h0), v);
        chk("R8", "pointer wraps to way0", v, 32'd20);
    endtask

    task automatic t_inval_unknown;
        logic [31:0] v; int b; logic iv;
        do_cmd(3'd6, b, iv);
        chk("R9", "invalidate-only pulses", {31'd0, iv}, 32'h1);
        wr_reg(2'd2, 32'd13);
        do_cmd(3'd2, b, iv);
        rd_reg(2'd0, v);
        chk("R9", "invalidate-only keeps entries", v, mk0(19'd3, 1'b1, 1'b0, 8'h11));
        wr_reg(2'd3, 32'd0);
        chk("R11", "code 0 not accepted", {31'd0, busy}, 32'h0);
        wr_reg(2'd3, 32'd7);
        chk("R11", "code 7 not accepted", {31'd0, busy}, 32'h0);
        rd_reg(2'd0, v);
        chk("R11", "word0 unchanged", v, mk0(19'd3, 1'b1, 1'b0, 8'h11));
        rd_reg(2'd2, v);
        chk("R11", "index unchanged", v, 32'd13);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_write_read;
        t_probe;
        t_busy_ignore;
        t_dup;
        t_getidx;
        t_inval_unknown;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule